// File: doc/BRIEF.md
# Precise Trap Controller

This block keeps the exception bookkeeping for a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). Any stage may report a fault for the instruction it currently holds. The controller does not act on the fault in that stage. It attaches the fault to the instruction's own record, and that record moves down the pipe one stage per clock. The fault is acted on only when the instruction reaches writeback. As a result, traps are always taken in program order.

When a flagged instruction reaches writeback, the controller does four things in the same cycle:
- it signals a trap;
- it raises a squash line for every stage;
- it blocks the memory and register commits;
- it asks fetch to redirect to a fixed trap vector.

On the next edge it saves two values: the restart PC, in an interrupt address register, and the cause. If the faulting instruction sat in a branch delay slot, the controller sets a delay bit and saves the branch's PC, so a single saved address is enough to restart. Every instruction older than the faulting one has already committed by then. No younger instruction ever gets a commit enable. The pipeline advances every clock, and bubbles are marked by an invalid fetch.

Top module: `precise_trap_ctl`

## Requirements
- R1: While reset is held and in the first cycle after it, trap, squash, redirect, both commit enables, the saved PC, the cause and the delay bit are all zero.
- R2: Cause codes, lowest set bit winning within a stage:
  - fetch `f_exc` bit0/1/2 give 1 (page fault), 2 (misaligned), 3 (protection);
  - decode `d_exc` bit0/1 give 4 (illegal), 5 (privileged);
  - `x_exc` gives 6 (arithmetic);
  - memory `m_exc` bit0/1/2 give 8 (page fault), 9 (misaligned), 10 (protection).
- R3: A fault raised in stage s (fetch 0 … memory 3) in cycle t raises `trap_o` in cycle t+4-s, never earlier. Every older instruction gets `wb_ok_o` first; after a fetch fault that means exactly four commits before the trap.
- R4: In a trap cycle, `squash_o` is all ones, `redir_valid_o` is high and `redir_pc_o` equals TRAP_VEC. No instruction that was in flight in that cycle ever later gets a commit enable or raises a trap.
- R5: On the edge after a trap, `iar_o` and `cause_o` take the faulting PC and its code. They hold their value until the next trap.
- R6: An instruction is marked as a delay-slot instruction when `d_slot` is high while it is in decode. If it faults, `iar_o` becomes its PC minus INSN_BYTES and `bd_o` becomes 1; otherwise `bd_o` becomes 0.
- R7: If an older instruction faults in memory in the same cycle that a younger one faults in fetch, the memory fault is the one taken and the fetch fault is never taken.
- R8: Only the first fault of an instruction is kept; a later stage's fault on the same instruction does not change the recorded cause.
- R9: A fault on a younger instruction that is squashed by an older trap is dropped and never causes a trap.
- R10: `mem_ok_o` is high only when memory holds a valid instruction with no earlier fault, no memory fault this cycle and no trap this cycle. `wb_ok_o` is high only when writeback holds a valid instruction that has no fault.
- R11: Fault inputs for a stage that holds a bubble are ignored and never cause a trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| f_valid | input | 1 | Fetch holds a real instruction |
| f_pc | input | PC_W | PC of the fetched instruction |
| f_exc | input | 3 | Fetch faults: page, misaligned, protection |
| d_exc | input | 2 | Decode faults: illegal, privileged |
| d_slot | input | 1 | Instruction in decode is in a branch delay slot |
| x_exc | input | 1 | Execute arithmetic fault |
| m_exc | input | 3 | Memory faults: page, misaligned, protection |
| trap_o | output | 1 | Trap taken this cycle |
| squash_o | output | 5 | Per-stage squash, bit0 fetch … bit4 writeback |
| redir_valid_o | output | 1 | Fetch redirect request |
| redir_pc_o | output | PC_W | Redirect target (trap vector) |
| mem_ok_o | output | 1 | Memory-stage commit enable |
| wb_ok_o | output | 1 | Writeback commit enable |
| iar_o | output | PC_W | Saved restart PC |
| cause_o | output | 4 | Saved cause code |
| bd_o | output | 1 | Saved delay-slot bit |

## Verification
The hard cycle is the one where an older memory fault and a younger fetch fault arrive together. The same risk arises when an execute fault and a decode fault on the next instruction land in the same cycle. In both cases the write path to the saved registers and the squash path must pick the older fault alone. The bench sets up both collisions on purpose, with instructions staggered so the faults line up. A queue-based model then checks the trap cycle, the saved cause and address, and the absence of any second trap. A long random phase with sparse faults and delay-slot marks produces further collisions, and every output is compared with the model each cycle.

// File: rtl/precise_trap_ctl.sv
module precise_trap_ctl #(
  parameter int PC_W = 32,
  parameter int INSN_BYTES = 4,
  parameter logic [PC_W-1:0] TRAP_VEC = PC_W'(32'h80)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            f_valid,
  input  logic [PC_W-1:0] f_pc,
  input  logic [2:0]      f_exc,
  input  logic [1:0]      d_exc,
  input  logic            d_slot,
  input  logic            x_exc,
  input  logic [2:0]      m_exc,
  output logic            trap_o,
  output logic [4:0]      squash_o,
  output logic            redir_valid_o,
  output logic [PC_W-1:0] redir_pc_o,
  output logic            mem_ok_o,
  output logic            wb_ok_o,
  output logic [PC_W-1:0] iar_o,
  output logic [3:0]      cause_o,
  output logic            bd_o
);
  localparam int NST = 4;
  localparam int CW = 4;
  localparam int WB = NST;
  localparam int MS = NST - 1;

  logic [NST:1]    rv, rx, rs;
  logic [CW-1:0]   rc [NST:1];
  logic [PC_W-1:0] rp [NST:1];
  logic [CW-1:0]   code [0:NST-1];
  logic            trap;

  assign code[0] = f_exc[0] ? 4'd1 : f_exc[1] ? 4'd2 : f_exc[2] ? 4'd3 : 4'd0;
  assign code[1] = d_exc[0] ? 4'd4 : d_exc[1] ? 4'd5 : 4'd0;
  assign code[2] = x_exc ? 4'd6 : 4'd0;
  assign code[3] = m_exc[0] ? 4'd8 : m_exc[1] ? 4'd9 : m_exc[2] ? 4'd10 : 4'd0;

  assign trap          = rv[WB] & rx[WB];
  assign trap_o        = trap;
  assign squash_o      = {5{trap}};
  assign redir_valid_o = trap;
  assign redir_pc_o    = TRAP_VEC;
  assign mem_ok_o      = rv[MS] & ~rx[MS] & (code[MS] == '0) & ~trap;
  assign wb_ok_o       = rv[WB] & ~rx[WB];

  always_ff @(posedge clk) begin
    if (!rst_n || trap) begin
      rv <= '0;
      rx <= '0;
      rs <= '0;
      for (int k = 1; k <= NST; k++) begin
        rc[k] <= '0;
        rp[k] <= '0;
      end
    end else begin
      rv[1] <= f_valid;
      rx[1] <= f_valid & (code[0] != '0);
      rc[1] <= f_valid ? code[0] : '0;
      rp[1] <= f_pc;
      rs[1] <= 1'b0;
      for (int k = 2; k <= NST; k++) begin
        rv[k] <= rv[k-1];
        rp[k] <= rp[k-1];
        rs[k] <= rs[k-1] | ((k == 2) && d_slot && rv[1]);
        if (rv[k-1] && !rx[k-1] && code[k-1] != '0) begin
          rx[k] <= 1'b1;
          rc[k] <= code[k-1];
        end else begin
          rx[k] <= rx[k-1];
          rc[k] <= rc[k-1];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      iar_o   <= '0;
      cause_o <= '0;
      bd_o    <= 1'b0;
    end else if (trap) begin
      iar_o   <= rs[WB] ? rp[WB] - PC_W'(INSN_BYTES) : rp[WB];
      cause_o <= rc[WB];
      bd_o    <= rs[WB];
    end
  end

  // R3
  trap_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap |-> rc[WB] != '0);

  // R4
  flush_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap |=> rv == '0);

  // R5
  iar_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !trap |=> $stable(iar_o) && $stable(cause_o) && $stable(bd_o));

  // R6
  slot_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap |=> bd_o == $past(rs[WB]));

  // R8
  first_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rv[2] && rx[2] && !trap) |=> (rx[3] && rc[3] == $past(rc[2])));

  // R10
  commit_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap |-> !mem_ok_o && !wb_ok_o);
endmodule

// File: tb/sim_precise_trap_ctl.sv
module sim_precise_trap_ctl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic f_valid = 1'b0;
  logic [31:0] f_pc = '0;
  logic [2:0] f_exc = '0;
  logic [1:0] d_exc = '0;
  logic d_slot = 1'b0;
  logic x_exc = 1'b0;
  logic [2:0] m_exc = '0;
  logic trap_o, redir_valid_o, mem_ok_o, wb_ok_o, bd_o;
  logic [4:0] squash_o;
  logic [31:0] redir_pc_o, iar_o;
  logic [3:0] cause_o;

  always #10 clk = ~clk;

  precise_trap_ctl u0 (
    .clk(clk), .rst_n(rst_n), .f_valid(f_valid), .f_pc(f_pc), .f_exc(f_exc),
    .d_exc(d_exc), .d_slot(d_slot), .x_exc(x_exc), .m_exc(m_exc),
    .trap_o(trap_o), .squash_o(squash_o), .redir_valid_o(redir_valid_o),
    .redir_pc_o(redir_pc_o), .mem_ok_o(mem_ok_o), .wb_ok_o(wb_ok_o),
    .iar_o(iar_o), .cause_o(cause_o), .bd_o(bd_o));

  typedef struct {
    logic [31:0] pc;
    int cause;
    bit slot;
    int age;
  } ent_t;

  ent_t q[$];
  logic [31:0] m_iar = '0;
  int m_cause = 0;
  bit m_bd = 1'b0;
  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int wb_cnt = 0;
  int trap_cnt = 0;
  logic [31:0] pc_next = 32'h1000;

  function automatic int fcode(logic [2:0] e);
    if (e[0]) return 1;
    if (e[1]) return 2;
    if (e[2]) return 3;
    return 0;
  endfunction
  function automatic int dcode(logic [1:0] e);
    if (e[0]) return 4;
    if (e[1]) return 5;
    return 0;
  endfunction
  function automatic int mcode(logic [2:0] e);
    if (e[0]) return 8;
    if (e[1]) return 9;
    if (e[2]) return 10;
    return 0;
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
      summary();
    end
  end

  task automatic tick();
    int wi, mi, sc;
    bit t;
    ent_t nq[$];
    @(negedge clk);
    #2;
    wi = -1; mi = -1;
    foreach (q[i]) begin
      if (q[i].age == 4) wi = i;
      if (q[i].age == 3) mi = i;
    end
    t = (wi >= 0) && (q[wi].cause != 0);
    chk("R3", "trap", 32'(trap_o), 32'(t));
    chk("R4", "squash", 32'(squash_o), t ? 32'h1f : 32'h0);
    chk("R4", "redirect", 32'(redir_valid_o), 32'(t));
    chk("R4", "vector", redir_pc_o, 32'h80);
    chk("R10", "mem_ok", 32'(mem_ok_o),
        32'((mi >= 0) && q[mi].cause == 0 && mcode(m_exc) == 0 && !t));
    chk("R10", "wb_ok", 32'(wb_ok_o), 32'((wi >= 0) && q[wi].cause == 0));
    chk("R5", "iar", iar_o, m_iar);
    chk("R5", "cause", 32'(cause_o), 32'(m_cause));
    chk("R6", "bd", 32'(bd_o), 32'(m_bd));
    if (wb_ok_o) wb_cnt++;
    if (trap_o) trap_cnt++;
    @(posedge clk);
    #1;
    if (!rst_n) begin
      q.delete();
      m_iar = '0; m_cause = 0; m_bd = 1'b0;
    end else if (t) begin
      m_iar = q[wi].slot ? q[wi].pc - 32'd4 : q[wi].pc;
      m_cause = q[wi].cause;
      m_bd = q[wi].slot;
      q.delete();
    end else begin
      foreach (q[i]) begin
        ent_t e;
        e = q[i];
        if (e.age != 4) begin
          sc = (e.age == 1) ? dcode(d_exc) : (e.age == 2) ? (x_exc ? 6 : 0) : mcode(m_exc);
          if (e.cause == 0) e.cause = sc;
          if (e.age == 1 && d_slot) e.slot = 1'b1;
          e.age++;
          nq.push_back(e);
        end
      end
      if (f_valid) nq.push_back('{pc: f_pc, cause: fcode(f_exc), slot: 1'b0, age: 1});
      q = nq;
    end
  endtask

  task automatic quiet();
    f_valid = 0; f_exc = 0; d_exc = 0; d_slot = 0; x_exc = 0; m_exc = 0;
  endtask

  task automatic fetch(logic [2:0] fe);
    f_valid = 1; f_pc = pc_next; f_exc = fe;
    pc_next += 4;
  endtask

  task automatic drain();
    for (int i = 0; i < 6; i++) begin
      quiet();
      tick();
    end
  endtask

  initial begin
    logic [31:0] p0;
    int tc;
    quiet();
    tick();
    tick();
    // R1: reset values
    chk("R1", "reset trap", 32'(trap_o), 0);
    chk("R1", "reset iar", iar_o, 0);
    chk("R1", "reset wb_ok", 32'(wb_ok_o), 0);
    rst_n = 1;
    tick();
    chk("R1", "post-reset cause", 32'(cause_o), 0);

    // R3: fetch fault after four clean instructions
    for (int i = 0; i < 4; i++) begin
      quiet(); fetch(3'b000); tick();
    end
    wb_cnt = 0; tc = trap_cnt;
    quiet(); p0 = pc_next; fetch(3'b010); tick();
    for (int i = 0; i < 3; i++) begin
      quiet(); tick();
    end
    chk("R3", "commits before fetch trap", wb_cnt, 4);
    chk("R3", "no early trap", trap_cnt - tc, 0);
    quiet(); tick();
    chk("R3", "trap at writeback", trap_cnt - tc, 1);
    drain();
    chk("R2", "fetch misaligned code", 32'(cause_o), 2);
    chk("R5", "saved pc", iar_o, p0);

    // R7: memory fault older, fetch fault younger, same cycle
    p0 = pc_next;
    for (int i = 0; i < 3; i++) begin
      quiet(); fetch(3'b000); tick();
    end
    tc = trap_cnt;
    quiet(); fetch(3'b001); m_exc = 3'b001; tick();
    drain();
    chk("R7", "memory fault wins", 32'(cause_o), 8);
    chk("R7", "older pc saved", iar_o, p0);
    chk("R7", "single trap", trap_cnt - tc, 1);
    chk("R6", "bd clear", 32'(bd_o), 0);

    // R8: decode fault then memory fault on one instruction
    quiet(); p0 = pc_next; fetch(3'b000); tick();
    quiet(); d_exc = 2'b01; tick();
    quiet(); tick();
    quiet(); m_exc = 3'b010; tick();
    drain();
    chk("R8", "first cause kept", 32'(cause_o), 4);
    chk("R8", "pc", iar_o, p0);

    // R6: fault in a delay slot
    quiet(); p0 = pc_next; fetch(3'b000); tick();
    quiet(); fetch(3'b000); tick();
    quiet(); d_slot = 1; tick();
    quiet(); x_exc = 1; tick();
    drain();
    chk("R6", "branch pc saved", iar_o, p0);
    chk("R6", "bd set", 32'(bd_o), 1);
    chk("R2", "arith code", 32'(cause_o), 6);

    // R9: younger decode fault squashed by older execute fault
    quiet(); p0 = pc_next; fetch(3'b000); tick();
    quiet(); fetch(3'b000); tick();
    tc = trap_cnt;
    quiet(); x_exc = 1; d_exc = 2'b10; tick();
    drain();
    chk("R9", "one trap only", trap_cnt - tc, 1);
    chk("R9", "older cause", 32'(cause_o), 6);

    // R11: faults on bubbles
    tc = trap_cnt;
    quiet(); f_exc = 3'b111; d_exc = 2'b11; x_exc = 1; m_exc = 3'b111; tick();
    quiet(); d_exc = 2'b10; x_exc = 1; m_exc = 3'b100; tick();
    drain();
    chk("R11", "no trap from bubbles", trap_cnt - tc, 0);

    // random mix, compared to the model every cycle (R2..R10)
    for (int i = 0; i < 3000; i++) begin
      quiet();
      if ($urandom % 5 != 0) fetch(($urandom % 20 == 0) ? 3'(1 << ($urandom % 3)) : 3'b000);
      if ($urandom % 25 == 0) d_exc = 2'(1 + $urandom % 3);
      if ($urandom % 6 == 0) d_slot = 1;
      if ($urandom % 25 == 0) x_exc = 1;
      if ($urandom % 25 == 0) m_exc = 3'(1 + $urandom % 7);
      if (i == 1500) pc_next = 32'h0000_0000;
      tick();
    end
    drain();
    summary();
  end
endmodule